// File: doc/BRIEF.md
# Wired-Interrupt to Message Converter

This block turns a bank of wired interrupt lines into posted interrupt messages. Each line is first synchronized and then watched for either a rising edge or a high level, as selected per line. An activation sets a per-line status bit, and one message is produced for each time a status bit becomes set. A message carries a 12-bit device id and a 10-bit event id, both taken from a per-line vector register. The message address is a constant outside this block, so only the data words travel on the output.

The lines are grouped into nodes of 128. The line with global number h (numbering starts at 64, and 0..63 are reserved) belongs to node (h-64)/128+1, at pin (h-64) mod 128. Each node decodes its own 4 KiB window in a simple register port, and a global write-one-to-clear status region sits at 0xA000. A line that has sent its message stays quiet until software clears its status bit. Lines waiting to send are served in round-robin order, and the output follows a valid/ready handshake.

Top module: `wire2msg_gen`

## Requirements
- R1: After a synchronous reset, msg_valid is 0, reg_rdata is 0, every status bit is 0, and every trigger bit is 0, which selects rising-edge mode.
- R2: Node n (1..NUM_NODES) decodes the window at n*0x1000, or at (n+1)*0x1000 when n is 10 or more. Pin p of node n is input bit (n-1)*128+p and has global number h = 64+(n-1)*128+p.
- R3: The vector register of pin p is at window+0x200+p*4. Bits 21:12 hold the event id and bits 11:0 hold the device id. A read returns the stored fields with bits 31:22 zero. Read data is registered and appears one cycle after the address.
- R4: The trigger bit of pin p is at window+(p/32)*4, bit p%32, and can be written and read. A 1 selects level-high mode and a 0 selects rising-edge mode.
- R5: In rising-edge mode, a rising edge on a line sets its status bit and produces exactly one message. A line that stays high afterwards produces no further message, even after its status is cleared.
- R6: In level-high mode, a high line whose status is clear sets the status bit and produces one message. If the line is still high when the status is cleared, a new message follows. If the line is low when the status is cleared, no message follows.
- R7: The status word for global number h is at 0xA000+(h/32)*4, bit h%32, and reads return the live status. Writing 1 to a bit clears that status and writing 0 leaves it unchanged. When a new activation arrives in the same cycle as a clear, the activation wins.
- R8: Message data is {device id, event id} from the line's vector register at issue time. While msg_valid is high and msg_ready is low, msg_valid stays high and the data stays stable.
- R9: Lines waiting to send are granted in round-robin order, starting the search at the line after the last one granted. After reset the search starts at line 0.
- R10: Unmapped addresses read zero and ignore writes. These include window slot 0, windows of nodes that do not exist, gaps inside a window, and status words for reserved numbers below 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_NODES*128 | Wired interrupt lines, asynchronous |
| reg_addr | input | ADDR_W | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_dev_id | output | 12 | Device id of the message |
| msg_event_id | output | 10 | Event id of the message |

## Verification
In the first pattern, a single line rises and then stays high. This shows that edge mode counts one event per edge and does not re-arm when status is cleared. In the second pattern, a level line is held high across a status clear and then released before a second clear. This separates re-assertion from one-shot behaviour. Another pattern raises three lines spread over both nodes in the same cycle while the output is stalled, which exposes the grant order, the wrap-around and the mapping between pin and node. A lone stalled message tests data hold. Writes to holes in the address map, followed by reads of live registers, show that stray accesses reach nothing.

// File: rtl/w2m_pkg.sv
package w2m_pkg;
  localparam int WIN_SHIFT = 12;
  localparam int CLR_SLOT  = 10;
  localparam int VEC_OFS   = 'h200;
  localparam int IRQ_BASE  = 64;
  localparam int DEV_W     = 12;
  localparam int EVT_W     = 10;
  localparam int WORD_W    = 32;

  typedef struct packed {
    logic [EVT_W-1:0] evt;
    logic [DEV_W-1:0] dev;
  } vec_t;
endpackage

// File: rtl/w2m_pin_track.sv
module w2m_pin_track #(
  parameter int NUM_PINS = 256
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic [NUM_PINS-1:0] level_mode,
  input  logic [NUM_PINS-1:0] clr,
  input  logic [NUM_PINS-1:0] fire,
  output logic [NUM_PINS-1:0] status,
  output logic [NUM_PINS-1:0] sent,
  output logic [NUM_PINS-1:0] req
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic s1_q, s2_q, s3_q, st_q, sn_q, set_c;

    assign set_c = level_mode[i] ? (s2_q & ~st_q) : (s2_q & ~s3_q);

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
        st_q <= 1'b0;
        sn_q <= 1'b0;
      end else begin
        s1_q <= irq_in[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
        if (clr[i]) begin
          st_q <= set_c;
          sn_q <= 1'b0;
        end else begin
          if (set_c) st_q <= 1'b1;
          if (fire[i]) sn_q <= 1'b1;
        end
      end
    end

    assign status[i] = st_q;
    assign sent[i]   = sn_q;
    assign req[i]    = st_q & ~sn_q;
  end
endmodule

// File: rtl/w2m_rr_arb.sv
module w2m_rr_arb #(
  parameter int N = 256,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  input  logic             take,
  output logic             found,
  output logic [IDX_W-1:0] gidx,
  output logic [N-1:0]     grant
);
  logic [IDX_W-1:0] last_q;

  always_comb begin
    found = 1'b0;
    gidx  = '0;
    for (int k = 0; k < N; k++) begin
      if (!found && req[(int'(last_q) + 1 + k) % N]) begin
        found = 1'b1;
        gidx  = IDX_W'((int'(last_q) + 1 + k) % N);
      end
    end
    grant = '0;
    if (found) grant[gidx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= IDX_W'(N - 1);
    else if (take) last_q <= gidx;
  end
endmodule

// File: rtl/w2m_cfg_regs.sv
module w2m_cfg_regs
  import w2m_pkg::*;
#(
  parameter int NUM_NODES     = 2,
  parameter int PINS_PER_NODE = 128,
  parameter int ADDR_W        = 16,
  localparam int NUM_PINS     = NUM_NODES * PINS_PER_NODE,
  localparam int IDX_W        = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                we,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata,
  input  logic [NUM_PINS-1:0] status_i,
  output logic [NUM_PINS-1:0] level_o,
  output logic [NUM_PINS-1:0] clr_o,
  input  logic [IDX_W-1:0]    vec_idx_i,
  output vec_t                vec_o
);
  localparam int TYPE_BYTES = (PINS_PER_NODE / WORD_W) * 4;
  localparam int VEC_END    = VEC_OFS + PINS_PER_NODE * 4;

  vec_t                vec_q [NUM_PINS];
  logic [NUM_PINS-1:0] type_q;
  logic                type_hit, vec_hit, clr_hit;
  logic [IDX_W-1:0]    t_base, v_idx, c_base;
  logic [WORD_W-1:0]   rd_next;
  logic                unused_lsb;

  assign unused_lsb = ^addr[1:0];

  always_comb begin
    int slot, ofs, node, word;
    logic node_ok;
    slot    = int'(addr[ADDR_W-1:WIN_SHIFT]);
    ofs     = int'(addr[WIN_SHIFT-1:0]);
    node    = (slot < CLR_SLOT) ? slot : slot - 1;
    word    = ofs / 4;
    node_ok = (slot != CLR_SLOT) && (node >= 1) && (node <= NUM_NODES);
    type_hit = node_ok && (ofs < TYPE_BYTES);
    vec_hit  = node_ok && (ofs >= VEC_OFS) && (ofs < VEC_END);
    clr_hit  = (slot == CLR_SLOT) && (word * WORD_W >= IRQ_BASE) &&
               (word * WORD_W < IRQ_BASE + NUM_PINS);
    t_base = IDX_W'((node - 1) * PINS_PER_NODE + word * WORD_W);
    v_idx  = IDX_W'((node - 1) * PINS_PER_NODE + (ofs - VEC_OFS) / 4);
    c_base = IDX_W'(word * WORD_W - IRQ_BASE);
  end

  always_ff @(posedge clk) begin
    if (we && vec_hit) vec_q[v_idx] <= vec_t'(wdata[EVT_W+DEV_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) type_q <= '0;
    else if (we && type_hit) type_q[t_base +: WORD_W] <= wdata;
  end

  always_comb begin
    clr_o = '0;
    if (we && clr_hit) clr_o[c_base +: WORD_W] = wdata;
  end

  always_comb begin
    rd_next = '0;
    if (type_hit)     rd_next = type_q[t_base +: WORD_W];
    else if (vec_hit) rd_next = WORD_W'(vec_q[v_idx]);
    else if (clr_hit) rd_next = status_i[c_base +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else rdata <= rd_next;
  end

  assign level_o = type_q;
  assign vec_o   = vec_q[vec_idx_i];
endmodule

// File: rtl/wire2msg_gen.sv
module wire2msg_gen
  import w2m_pkg::*;
#(
  parameter int NUM_NODES     = 2,
  parameter int PINS_PER_NODE = 128,
  parameter int ADDR_W        = 16,
  localparam int NUM_PINS     = NUM_NODES * PINS_PER_NODE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_we,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [DEV_W-1:0]    msg_dev_id,
  output logic [EVT_W-1:0]    msg_event_id
);
  localparam int IDX_W = $clog2(NUM_PINS);

  logic [NUM_PINS-1:0] trk_status, trk_sent, trk_req, cfg_level, cfg_clr;
  logic [NUM_PINS-1:0] arb_grant, grant_fire;
  logic [IDX_W-1:0]    arb_idx;
  logic                arb_found, take;
  vec_t                vec_rd;

  w2m_cfg_regs #(
    .NUM_NODES(NUM_NODES), .PINS_PER_NODE(PINS_PER_NODE), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .rdata(reg_rdata), .status_i(trk_status), .level_o(cfg_level),
    .clr_o(cfg_clr), .vec_idx_i(arb_idx), .vec_o(vec_rd)
  );

  w2m_pin_track #(.NUM_PINS(NUM_PINS)) u_trk (
    .clk(clk), .rst(rst), .irq_in(irq_in), .level_mode(cfg_level),
    .clr(cfg_clr), .fire(grant_fire), .status(trk_status),
    .sent(trk_sent), .req(trk_req)
  );

  w2m_rr_arb #(.N(NUM_PINS)) u_arb (
    .clk(clk), .rst(rst), .req(trk_req), .take(take),
    .found(arb_found), .gidx(arb_idx), .grant(arb_grant)
  );

  assign take       = arb_found && (!msg_valid || msg_ready);
  assign grant_fire = take ? arb_grant : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid    <= 1'b0;
      msg_dev_id   <= '0;
      msg_event_id <= '0;
    end else if (take) begin
      msg_valid    <= 1'b1;
      msg_dev_id   <= vec_rd.dev;
      msg_event_id <= vec_rd.evt;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wire2msg_gen_chk.sv
module wire2msg_gen_chk #(
  parameter int NUM_PINS = 256
) (
  input logic                clk,
  input logic                rst,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [11:0]         msg_dev_id,
  input logic [9:0]          msg_event_id,
  input logic [31:0]         reg_rdata,
  input logic [NUM_PINS-1:0] arb_grant,
  input logic [NUM_PINS-1:0] trk_sent
);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!msg_valid && reg_rdata == 32'h0));

  a_r8_hold_while_stalled: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dev_id) && $stable(msg_event_id)));

  a_r9_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(arb_grant));

  a_r5_no_regrant_of_sent: assert property (@(posedge clk) disable iff (rst)
    (arb_grant & trk_sent) == '0);
endmodule

bind wire2msg_gen wire2msg_gen_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_dev_id(msg_dev_id), .msg_event_id(msg_event_id), .reg_rdata(reg_rdata),
  .arb_grant(arb_grant), .trk_sent(trk_sent)
);

// File: tb/wire2msg_gen_tb_top.sv
module wire2msg_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_NODES  = 2;
  localparam int NUM_PINS   = NUM_NODES * 128;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [NUM_PINS-1:0] irq = '0;
  logic [15:0]         addr = '0;
  logic                we = 1'b0;
  logic [31:0]         wdata = '0;
  logic [31:0]         rdata;
  logic                msg_valid;
  logic                msg_ready = 1'b1;
  logic [11:0]         dev;
  logic [9:0]          evt;

  int n_checks = 0;
  int n_fail   = 0;
  int n_msg    = 0;
  logic [11:0] log_dev [64];
  logic [9:0]  log_evt [64];

  always #(CLK_PERIOD / 2) clk = ~clk;

  wire2msg_gen #(.NUM_NODES(NUM_NODES)) dut_i (
    .clk(clk), .rst(rst), .irq_in(irq), .reg_addr(addr), .reg_we(we),
    .reg_wdata(wdata), .reg_rdata(rdata), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_dev_id(dev), .msg_event_id(evt)
  );

  always @(negedge clk) begin
    if (!rst && msg_valid && msg_ready) begin
      log_dev[n_msg % 64] = dev;
      log_evt[n_msg % 64] = evt;
      n_msg++;
    end
  end

  function automatic logic [15:0] win(int n);
    return (n >= 10) ? 16'((n + 1) * 4096) : 16'(n * 4096);
  endfunction
  function automatic logic [15:0] vec_addr(int n, int p);
    return win(n) + 16'h200 + 16'(p * 4);
  endfunction
  function automatic logic [15:0] type_addr(int n, int p);
    return win(n) + 16'((p / 32) * 4);
  endfunction
  function automatic logic [15:0] clr_addr(int h);
    return 16'hA000 + 16'((h / 32) * 4);
  endfunction

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic bus_wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 msg_valid", 32'(msg_valid), 32'h0);
    check("R1 rdata", rdata, 32'h0);
    bus_rd(clr_addr(64), d);
    check("R1 status", d, 32'h0);
    bus_rd(type_addr(2, 0), d);
    check("R1 type", d, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_wr(vec_addr(2, 127), 32'hFFFF_FFFF);
    bus_rd(vec_addr(2, 127), d);
    check("R3 vector upper bits zero", d, 32'h003F_FFFF);
    bus_wr(vec_addr(1, 0), 32'h0000_5A5A);
    bus_rd(vec_addr(1, 0), d);
    check("R3 vector readback", d, 32'h0000_5A5A);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_wr(16'h0200, 32'hFFFF_FFFF);
    bus_wr(16'h3200, 32'hFFFF_FFFF);
    bus_wr(16'h1100, 32'hFFFF_FFFF);
    bus_wr(16'hA000, 32'hFFFF_FFFF);
    bus_rd(16'h0200, d); check("R10 slot0", d, 32'h0);
    bus_rd(16'h3200, d); check("R10 absent node", d, 32'h0);
    bus_rd(16'h1100, d); check("R10 window gap", d, 32'h0);
    bus_rd(16'hA000, d); check("R10 reserved status", d, 32'h0);
    bus_rd(vec_addr(1, 0), d); check("R10 vector untouched", d, 32'h0000_5A5A);
    bus_rd(type_addr(1, 0), d); check("R10 type untouched", d, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    int c0 = n_msg;
    bus_wr(vec_addr(1, 5), {10'h0, 10'h155, 12'h12A});
    irq[5] = 1'b1;
    settle(10);
    check("R5 one message", 32'(n_msg), 32'(c0 + 1));
    check("R8 device id", 32'(log_dev[c0 % 64]), 32'h12A);
    check("R8 event id", 32'(log_evt[c0 % 64]), 32'h155);
    settle(20);
    check("R5 held high no repeat", 32'(n_msg), 32'(c0 + 1));
    bus_rd(clr_addr(69), d);
    check("R7 status set", d, 32'h20);
    bus_wr(clr_addr(69), 32'h0);
    bus_rd(clr_addr(69), d);
    check("R7 zero write no effect", d, 32'h20);
    bus_wr(clr_addr(69), 32'h20);
    bus_rd(clr_addr(69), d);
    check("R7 one clears", d, 32'h0);
    settle(10);
    check("R5 no re-arm after clear", 32'(n_msg), 32'(c0 + 1));
    irq[5] = 1'b0;
  endtask

  task automatic t_level();
    logic [31:0] d;
    int c0 = n_msg;
    bus_wr(type_addr(2, 2), 32'h4);
    bus_rd(type_addr(2, 2), d);
    check("R4 type readback", d, 32'h4);
    bus_wr(vec_addr(2, 2), {10'h0, 10'h2A1, 12'h0C3});
    irq[130] = 1'b1;
    settle(10);
    check("R6 first message", 32'(n_msg), 32'(c0 + 1));
    check("R2 node2 device id", 32'(log_dev[c0 % 64]), 32'h0C3);
    settle(15);
    check("R6 single while set", 32'(n_msg), 32'(c0 + 1));
    bus_wr(clr_addr(194), 32'h4);
    settle(10);
    check("R6 re-assert after clear", 32'(n_msg), 32'(c0 + 2));
    irq[130] = 1'b0;
    settle(5);
    bus_wr(clr_addr(194), 32'h4);
    settle(10);
    check("R6 low no new message", 32'(n_msg), 32'(c0 + 2));
    bus_rd(clr_addr(194), d);
    check("R6 status clear", d, 32'h0);
  endtask

  task automatic t_hold();
    int c0 = n_msg;
    int bad = 0;
    bus_wr(vec_addr(1, 40), {10'h0, 10'h0AA, 12'hB0B});
    @(negedge clk);
    msg_ready = 1'b0;
    irq[40] = 1'b1;
    settle(8);
    @(negedge clk);
    check("R8 valid while stalled", 32'(msg_valid), 32'h1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!msg_valid || dev !== 12'hB0B || evt !== 10'h0AA) bad++;
    end
    check("R8 stable while stalled", 32'(bad), 32'h0);
    msg_ready = 1'b1;
    settle(3);
    check("R8 accepted once", 32'(n_msg), 32'(c0 + 1));
    irq[40] = 1'b0;
    bus_wr(clr_addr(104), 32'h100);
  endtask

  task automatic t_rr();
    int c0 = n_msg;
    bus_wr(vec_addr(1, 3),   {10'h0, 10'h003, 12'd3});
    bus_wr(vec_addr(1, 100), {10'h0, 10'h064, 12'd100});
    bus_wr(vec_addr(2, 122), {10'h0, 10'h0FA, 12'd250});
    @(negedge clk);
    msg_ready = 1'b0;
    irq[3] = 1'b1; irq[100] = 1'b1; irq[250] = 1'b1;
    settle(8);
    @(negedge clk);
    check("R9 first grant after last", 32'(dev), 32'd100);
    msg_ready = 1'b1;
    settle(6);
    check("R9 three messages", 32'(n_msg), 32'(c0 + 3));
    check("R9 order 1", 32'(log_dev[c0 % 64]), 32'd100);
    check("R9 order 2", 32'(log_dev[(c0 + 1) % 64]), 32'd250);
    check("R9 order 3 wrap", 32'(log_dev[(c0 + 2) % 64]), 32'd3);
    irq[3] = 1'b0; irq[100] = 1'b0; irq[250] = 1'b0;
    bus_wr(clr_addr(67), 32'h8);
    bus_wr(clr_addr(164), 32'h10);
    bus_wr(clr_addr(314), 32'h0400_0000);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_unmapped();
    t_edge();
    t_level();
    t_hold();
    t_rr();
    settle(5);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule